// File: doc/BRIEF.md
# Double-Rate Read Burst Output Sequencer

This block produces the read side of a double-data-rate memory device. It runs on a clock at twice the command rate, so every tick is one half command cycle and carries one data beat. Commands and their address are sampled only on command edges, which are the ticks where the free-running strobe is low. A READ is delivered after a per-command latency. The latency is counted in whole command cycles. Delivery is a burst of four words taken from a small internal register file.

A data-valid flag leads the data by one tick. Two output-enable bits stand in for the high-impedance state of the two 9-bit lanes. Reads spaced two command cycles apart join into one unbroken stream. A READ whose beats would land on ticks already claimed by an earlier read is dropped. The earlier read is left untouched. A WRITE is only acknowledged.

Top module: `rbs_read_seq`

## Requirements
- R1: A command is taken only on an edge where `qk` is low just before the edge. `cmd` is encoded as 2'b01 READ and 2'b10 WRITE, and any other value is no operation. A command presented while `qk` is high has no effect on any output.
- R2: A READ accepted at edge e with latency L drives beats in the four ticks starting after edge e+2*max(L,1)+1. Beat k carries the word of address (addr+k) mod 16. The word of address a is (a*9973+4242) mod 2^18.
- R3: `qvld` is high in the tick just before every beat, so it rises one tick before the first beat of a burst.
- R4: `qvld` is low during the last beat of a burst that no other burst follows.
- R5: While no beat is driven, both `dq_oe` bits are low and `dq` is all zero.
- R6: Two READs accepted two command cycles (four ticks) apart with the same latency give eight back-to-back beats, and `qvld` stays high for eight ticks in a row.
- R7: Both `qk` bits are equal and toggle every tick. They are held low during reset.
- R8: `dq_oe[0]` covers `dq[8:0]` and `dq_oe[1]` covers `dq[17:9]`, and the two bits always switch together.
- R9: Each READ samples its own latency. A READ whose beat ticks overlap any in-flight beat is ignored without disturbing the earlier burst. Non-overlapping reads with different latencies are delivered at their own ticks.
- R10: An accepted WRITE raises `wr_ack` for exactly the tick after its edge and leaves any read in progress unchanged.
- R11: A synchronous active-high `rst` cancels all in-flight beats, drops `qvld`, `dq_oe` and `wr_ack`, and holds the phase at the command slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, one tick per half command cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code (READ 01, WRITE 10) |
| addr | input | 4 | Start address of the read burst |
| rd_lat | input | 3 | Read latency in command cycles, 0 treated as 1 |
| qk | output | 2 | Free-running output strobes, one per lane |
| dq | output | 18 | Read data, two 9-bit lanes |
| dq_oe | output | 2 | Per-lane output enable, low models high impedance |
| qvld | output | 1 | Data-valid flag leading the data by one tick |
| wr_ack | output | 1 | One-tick WRITE acknowledge |

## Verification
The hardest case to create is a collision between reads with different latencies. In that case a later READ with a short latency reaches back into ticks that an earlier READ with a long latency already claimed, or lands in the gap in front of it. The bench reaches this case with a directed pair and then with a long pseudo-random stream of commands on both clock phases with a varying latency. A ring-indexed beat model in the bench predicts every tick's strobe, enable, data, valid flag and acknowledge from the rules alone.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } rbs_cmd_e;

  // latency in command cycles, a zero setting behaves as one
  function automatic int unsigned lat_cycles(input int unsigned lat);
    return (lat == 0) ? 1 : lat;
  endfunction

  // pipeline slot (after the shift) that holds the first beat of a read
  function automatic int unsigned first_slot(input int unsigned lat);
    return 2 * lat_cycles(lat);
  endfunction

  // content of the storage word at a given address
  function automatic logic [31:0] word_seed(input int unsigned a);
    return a * 32'd9973 + 32'd4242;
  endfunction

endpackage

// File: rtl/rbs_cmd_slot.sv
module rbs_cmd_slot
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LAT_W-1:0]  rd_lat,
  output logic              phase,
  output logic              rd_go,
  output logic [ADDR_W-1:0] go_addr,
  output logic [LAT_W-1:0]  go_lat,
  output logic              wr_ack
);

  logic phase_q;
  logic wr_go;
  logic wr_ack_q;

  // command edge = phase low before the edge
  always_comb begin
    rd_go   = !phase_q && (cmd == CMD_READ);
    wr_go   = !phase_q && (cmd == CMD_WRITE);
    go_addr = addr;
    go_lat  = rd_lat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      wr_ack_q <= 1'b0;
    end else begin
      phase_q  <= !phase_q;
      wr_ack_q <= wr_go;
    end
  end

  assign phase  = phase_q;
  assign wr_ack = wr_ack_q;

  // R7: phase alternates every tick once out of reset
  a_r7_phase_toggles: assert property (@(posedge clk) disable iff (rst)
    phase_q |=> !phase_q);
  a_r7_phase_returns: assert property (@(posedge clk) disable iff (rst)
    !phase_q |=> phase_q);
  // R10: acknowledge only ever follows a command edge
  a_r10_ack_on_slot: assert property (@(posedge clk) disable iff (rst)
    wr_ack_q |-> $past(!phase_q));

endmodule

// File: rtl/rbs_beat_sched.sv
module rbs_beat_sched
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LAT_W  = 3,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [LAT_W-1:0]  go_lat,
  output logic              rd_taken,
  output logic              head_v,
  output logic [ADDR_W-1:0] head_addr,
  output logic              next_v
);

  localparam int MAX_LAT = (1 << LAT_W) - 1;
  localparam int DEPTH   = 2 * MAX_LAT + BURST;

  logic [DEPTH-1:0]  v_q, v_sh, v_n, claim;
  logic [ADDR_W-1:0] a_q  [DEPTH];
  logic [ADDR_W-1:0] a_sh [DEPTH];
  logic [ADDR_W-1:0] a_n  [DEPTH];
  logic              clash;
  int unsigned       base;

  assign base = first_slot(int'(go_lat));

  // shifted view and slots a new read would claim
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      assign v_sh[i] = v_q[i+1];
      assign a_sh[i] = a_q[i+1];
    end else begin : g_top
      assign v_sh[i] = 1'b0;
      assign a_sh[i] = '0;
    end
    assign claim[i] = (i >= int'(base)) && (i < int'(base) + BURST);
  end

  assign clash    = |(claim & v_sh);
  assign rd_taken = rd_go && !clash;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      v_n[i] = v_sh[i];
      a_n[i] = a_sh[i];
      if (rd_taken && claim[i]) begin
        v_n[i] = 1'b1;
        a_n[i] = go_addr + ADDR_W'(i - int'(base));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) a_q[i] <= '0;
    end else begin
      v_q <= v_n;
      for (int i = 0; i < DEPTH; i++) a_q[i] <= a_n[i];
    end
  end

  assign head_v    = v_q[0];
  assign head_addr = a_q[0];
  assign next_v    = v_q[1];

  // R9: a taken read never lands on a beat already in flight
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    rd_taken |-> ((claim & v_sh) == '0));
  // R9: a refused read leaves the schedule as the shift alone makes it
  a_r9_refused_quiet: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !rd_taken) |=> (v_q == $past(v_sh)));

endmodule

// File: rtl/rbs_word_store.sv
module rbs_word_store
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  localparam int ENTRIES = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= WORD_W'(word_seed(e));
    end
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/rbs_out_lane.sv
module rbs_out_lane #(
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_v,
  input  logic [LANE_W-1:0] beat_bits,
  output logic [LANE_W-1:0] dq,
  output logic              oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe <= 1'b0;
      dq <= '0;
    end else begin
      oe <= beat_v;
      dq <= beat_v ? beat_bits : '0;
    end
  end

  // R5: a disabled lane carries no data
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (dq == '0));

endmodule

// File: rtl/rbs_read_seq.sv
module rbs_read_seq
  import rbs_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 4,
  parameter int LAT_W  = 3,
  parameter int BURST  = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LAT_W-1:0]  rd_lat,
  output logic [LANES-1:0]  qk,
  output logic [WORD_W-1:0] dq,
  output logic [LANES-1:0]  dq_oe,
  output logic              qvld,
  output logic              wr_ack
);

  localparam int LANE_W = WORD_W / LANES;

  logic              phase;
  logic              rd_go, rd_taken;
  logic [ADDR_W-1:0] go_addr;
  logic [LAT_W-1:0]  go_lat;
  logic              head_v, next_v;
  logic [ADDR_W-1:0] head_addr;
  logic [WORD_W-1:0] head_word;
  logic              qvld_q;

  rbs_cmd_slot #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_slot (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .rd_lat(rd_lat),
    .phase(phase), .rd_go(rd_go), .go_addr(go_addr), .go_lat(go_lat),
    .wr_ack(wr_ack)
  );

  rbs_beat_sched #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .BURST(BURST)) u_sched (
    .clk(clk), .rst(rst), .rd_go(rd_go), .go_addr(go_addr), .go_lat(go_lat),
    .rd_taken(rd_taken), .head_v(head_v), .head_addr(head_addr),
    .next_v(next_v)
  );

  rbs_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .rd_addr(head_addr), .rd_word(head_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rbs_out_lane #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst(rst), .beat_v(head_v),
      .beat_bits(head_word[g*LANE_W +: LANE_W]),
      .dq(dq[g*LANE_W +: LANE_W]), .oe(dq_oe[g])
    );
  end

  // valid flag looks one slot further ahead than the lanes
  always_ff @(posedge clk) begin
    if (rst) qvld_q <= 1'b0;
    else     qvld_q <= next_v;
  end

  assign qvld = qvld_q;
  assign qk   = {LANES{phase}};

  // R3: a high valid flag is followed by a driven beat
  a_r3_vld_leads: assert property (@(posedge clk) disable iff (rst)
    qvld_q |=> dq_oe[0]);
  // R4: a low valid flag is followed by an idle tick
  a_r4_vld_ends: assert property (@(posedge clk) disable iff (rst)
    !qvld_q |=> !dq_oe[0]);
  // R8: lane enables switch together
  a_r8_lanes_agree: assert property (@(posedge clk) disable iff (rst)
    dq_oe[0] == dq_oe[LANES-1]);

endmodule

// File: tb/rbs_read_seq_test.sv
module rbs_read_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd = 2'b00;
  logic [3:0]  addr = '0;
  logic [2:0]  lat = '0;
  logic [1:0]  qk;
  logic [17:0] dq;
  logic [1:0]  dq_oe;
  logic        qvld;
  logic        wr_ack;

  always #5 clk = ~clk;

  rbs_read_seq uut (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .rd_lat(lat),
    .qk(qk), .dq(dq), .dq_oe(dq_oe), .qvld(qvld), .wr_ack(wr_ack)
  );

  int checks = 0;
  int errors = 0;
  int ec = 0;
  bit mph = 1'b0;
  bit e_oe [64];
  bit e_qv [64];
  bit e_ack[64];
  logic [17:0] e_dq[64];
  int beats, run, run_max;
  int unsigned lcg = 32'h1234_5678;

  function automatic logic [17:0] wexp(int a);
    return 18'((a * 9973 + 4242) % 262144);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin
      e_oe[i] = 0; e_qv[i] = 0; e_ack[i] = 0; e_dq[i] = '0;
    end
  endtask

  task automatic step(bit r, logic [1:0] c, logic [3:0] a, logic [2:0] l);
    int e, rl, b, s;
    bit hit;
    rst = r; cmd = c; addr = a; lat = l;
    if (!r && !mph) begin
      e = ec + 1;
      if (c == 2'b01) begin
        rl = (l == 0) ? 1 : int'(l);
        b = e + 2 * rl + 1;
        hit = 0;
        for (int k = 0; k < 4; k++) hit |= e_oe[(b + k) & 63];
        if (!hit) begin
          for (int k = 0; k < 4; k++) begin
            e_oe[(b + k) & 63] = 1;
            e_qv[(b + k - 1) & 63] = 1;
            e_dq[(b + k) & 63] = wexp((int'(a) + k) % 16);
          end
        end
      end else if (c == 2'b10) begin
        e_ack[e & 63] = 1;
      end
    end
    @(posedge clk);
    ec++;
    if (r) begin clear_model(); mph = 0; end
    else mph = ~mph;
    @(negedge clk);
    s = ec & 63;
    chk(qk == {mph, mph}, "R7", "qk", qk, {mph, mph});
    chk(dq_oe == {e_oe[s], e_oe[s]}, "R8", "dq_oe", dq_oe, {e_oe[s], e_oe[s]});
    chk(dq == (e_oe[s] ? e_dq[s] : 18'h0), e_oe[s] ? "R2" : "R5", "dq", dq,
        e_oe[s] ? e_dq[s] : 18'h0);
    chk(qvld == e_qv[s], e_qv[s] ? "R3" : "R4", "qvld", qvld, e_qv[s]);
    chk(wr_ack == e_ack[s], "R10", "wr_ack", wr_ack, e_ack[s]);
    if (dq_oe[0]) beats++;
    if (qvld) begin run++; if (run > run_max) run_max = run; end
    else run = 0;
    e_oe[s] = 0; e_qv[s] = 0; e_ack[s] = 0; e_dq[s] = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'b00, 4'h0, 3'd0);
  endtask

  task automatic to_slot();
    if (mph) idle(1);
  endtask

  task automatic zero_stats();
    beats = 0; run = 0; run_max = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_model();
    @(negedge clk);
    // R11: reset state
    step(1, 2'b01, 4'h3, 3'd1);
    step(1, 2'b01, 4'h3, 3'd1);
    chk(dq_oe == 2'b00 && qvld == 0 && wr_ack == 0 && qk == 2'b00, "R11",
        "reset outputs", {dq_oe, qvld, wr_ack, qk}, 0);

    // R2: single read at every latency setting
    for (int l = 0; l < 8; l++) begin
      zero_stats(); to_slot();
      step(0, 2'b01, 4'(l * 3), 3'(l));
      idle(24);
      chk(beats == 4, "R2", "beat count", beats, 4);
      chk(run_max == 4, "R3", "valid length", run_max, 4);
    end

    // R1: command presented while qk is high is ignored
    zero_stats(); to_slot(); idle(1);
    step(0, 2'b01, 4'h5, 3'd2);
    step(0, 2'b00, 4'h0, 3'd0);
    step(0, 2'b10, 4'h0, 3'd0);
    idle(24);
    chk(beats == 0, "R1", "beats from off-slot read", beats, 0);

    // R6: reads four ticks apart merge seamlessly
    for (int l = 1; l < 8; l += 3) begin
      zero_stats(); to_slot();
      step(0, 2'b01, 4'hE, 3'(l));
      idle(3);
      step(0, 2'b01, 4'h2, 3'(l));
      idle(30);
      chk(beats == 8, "R6", "merged beats", beats, 8);
      chk(run_max == 8, "R6", "unbroken valid", run_max, 8);
    end

    // R9: overlapping read is dropped, earlier one intact
    zero_stats(); to_slot();
    step(0, 2'b01, 4'h1, 3'd4);
    idle(1);
    step(0, 2'b01, 4'h9, 3'd4);
    idle(30);
    chk(beats == 4, "R9", "overlap dropped", beats, 4);
    // R9: short latency read slots in ahead of a long one
    zero_stats(); to_slot();
    step(0, 2'b01, 4'h4, 3'd5);
    idle(1);
    step(0, 2'b01, 4'hB, 3'd2);
    idle(30);
    chk(beats == 8, "R9", "independent latencies", beats, 8);
    // R9: short latency read landing inside a long one is dropped
    zero_stats(); to_slot();
    step(0, 2'b01, 4'h4, 3'd3);
    idle(1);
    step(0, 2'b01, 4'hB, 3'd2);
    idle(30);
    chk(beats == 4, "R9", "late overlap dropped", beats, 4);

    // R10: write during a burst is acknowledged and does not cut it
    zero_stats(); to_slot();
    step(0, 2'b01, 4'h7, 3'd1);
    idle(3);
    step(0, 2'b10, 4'h0, 3'd0);
    idle(20);
    chk(beats == 4, "R10", "burst beside write", beats, 4);

    // R11: reset in the middle of a burst cancels it
    to_slot();
    step(0, 2'b01, 4'h2, 3'd1);
    idle(3);
    step(1, 2'b00, 4'h0, 3'd0);
    zero_stats();
    idle(20);
    chk(beats == 0, "R11", "beats after reset", beats, 0);

    // mixed stream on both phases with varying latency
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step(0, lcg[17:16], lcg[23:20], lcg[27:25]);
    end
    idle(30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule